// File: doc/BRIEF.md
# Simultaneous-Sampling Converter Bus Controller

This block sits on the host side of a multichannel successive-approximation converter whose channels all sample at the same moment and share one parallel data bus. On request it writes a 4-bit setup word into the converter. On a trigger it keeps every bus strobe idle for a quiet interval and then issues the convert-start edge. It waits for the active-low end-of-conversion flag, then reads the channels back with one read strobe each. The converter has no channel address: every rising edge of the read strobe moves its output to the next channel. The controller therefore counts strobes and delivers each result as a one-cycle sample on a stream output, tagged with its channel index and a last marker.

Every minimum width and interval is given in nanoseconds and turned into a whole number of system-clock cycles, rounding up. The shared bus has a separate input, output and output enable. The enable is active only while a setup word is being written. A trigger that arrives while the controller is busy is dropped and recorded in a sticky overrun flag.

Top module: `sar_bus_ctrl`

## Requirements
- R1: After reset, chip-select, read and write are high, convert-start is low, the bus output enable is low, no sample is valid and the overrun flag is clear.
- R2: A setup request taken in idle drives chip-select and write low together for ceil(max(WR_LOW_NS, WR_SETUP_NS)/CLK_PERIOD_NS) cycles, which is 4 at 5 ns. The output enable is high, with the setup word on data bits [3:0], from the cycle write falls until one cycle after write rises. The enable is low again in the next cycle.
- R3: After a trigger taken in idle, chip-select, read and write all stay high, and convert-start keeps its idle level, for exactly ceil(QUIET_NS/CLK_PERIOD_NS) cycles (100 at 5 ns) before convert-start changes.
- R4: Bit 0 of the last setup word written selects the start mode. With 0, convert-start idles low and rises when the quiet interval ends. With 1, it idles high and drops low for ceil(CNV_LOW_NS/CLK_PERIOD_NS) cycles (4 at 5 ns) before rising. The idle level follows the new bit from the cycle after the write completes.
- R5: Readout starts only after the end-of-conversion input has been seen high and then low after the convert-start edge. A low level left over from the previous conversion does not start a readout.
- R6: Each conversion produces exactly NUM_CH read strobes. Each strobe is low for ceil(max(RD_LOW_NS, RD_ACCESS_NS)/CLK_PERIOD_NS)+1 cycles (8 at 5 ns), and the strobe is high for ceil(RD_HIGH_NS/CLK_PERIOD_NS) cycles (2 at 5 ns) between strobes. Chip-select is low for one cycle before the first strobe falls and for the whole readout.
- R7: The data bus is sampled at the clock edge where read rises. The sample appears for one cycle with valid high in the cycle read is first high. The channel index runs 0 to NUM_CH-1 in strobe order, and the last marker is set only on index NUM_CH-1.
- R8: In start mode 0, convert-start stays high until the end-of-conversion fall is seen, and it is low throughout the readout.
- R9: The bus output enable is never high while read is low or in the cycle before read falls.
- R10: A trigger that arrives while the controller is not idle, or together with a setup request, starts no extra conversion. It sets an overrun flag that stays set until reset.
- R11: A setup request outside idle is ignored: write stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_i | input | 1 | Conversion request, taken when idle |
| cfg_wr_i | input | 1 | Setup write request, taken when idle |
| cfg_i | input | 4 | Setup word; bit 0 selects the start mode |
| csn_o | output | 1 | Chip select to converter, active low |
| rdn_o | output | 1 | Read strobe, active low |
| wrn_o | output | 1 | Write strobe, active low |
| cnvst_o | output | 1 | Convert-start |
| db_i | input | SAMPLE_W | Data bus from converter |
| db_o | output | SAMPLE_W | Data bus toward converter |
| db_oe_o | output | 1 | Output enable for db_o |
| eocn_i | input | 1 | End of conversion, active low, asynchronous |
| smp_valid_o | output | 1 | Sample valid, one cycle per channel |
| smp_data_o | output | SAMPLE_W | Captured sample |
| smp_ch_o | output | CH_W | Channel index of the sample |
| smp_last_o | output | 1 | Marks the final channel of a conversion |
| overrun_o | output | 1 | Sticky: a trigger was dropped |

## Verification
The bench builds the controller with six channels, a 16-bit bus and a 5 ns clock, keeping the default nanosecond limits. With six channels the index counter must stop at a value that is not a power of two, so both an early and a late last marker can be detected. The behavioural converter model returns valid data only from the seventh cycle of a read strobe. A read strobe even one cycle shorter than required therefore shows up as wrong data. The model also starts with a stale low end-of-conversion flag, so a controller that does not wait for the high-then-low sequence reads too early.

// File: rtl/sar_bus_pkg.sv
package sar_bus_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_WR_ACT,
    ST_WR_HOLD,
    ST_QUIET,
    ST_CNV_LOW,
    ST_CNV_WAIT,
    ST_RD_SETUP,
    ST_RD_LOW,
    ST_RD_HIGH,
    ST_RD_END
  } seq_state_t;

  typedef struct packed {
    logic csn;
    logic rdn;
    logic wrn;
    logic cnvst;
    logic oe;
  } bus_drv_t;

  // Whole cycles covering a time in ns, never less than one.
  function automatic int unsigned ns_to_cycles(input int unsigned ns,
                                               input int unsigned period_ns);
    int unsigned c;
    c = (ns + period_ns - 1) / period_ns;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // Strobe levels for a state; mode picks the convert-start style.
  function automatic bus_drv_t drive_for(input seq_state_t s, input logic mode);
    bus_drv_t d;
    d.csn   = 1'b1;
    d.rdn   = 1'b1;
    d.wrn   = 1'b1;
    d.oe    = 1'b0;
    d.cnvst = mode ? (s != ST_CNV_LOW) : (s == ST_CNV_WAIT);
    case (s)
      ST_WR_ACT: begin
        d.csn = 1'b0;
        d.wrn = 1'b0;
        d.oe  = 1'b1;
      end
      ST_WR_HOLD:  d.oe  = 1'b1;
      ST_RD_SETUP: d.csn = 1'b0;
      ST_RD_LOW: begin
        d.csn = 1'b0;
        d.rdn = 1'b0;
      end
      ST_RD_HIGH:  d.csn = 1'b0;
      ST_RD_END:   d.csn = 1'b0;
      default: ;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/sar_dwell_timer.sv
module sar_dwell_timer #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [CW-1:0] dwell_i,
  output logic          expired_o
);

  logic [CW-1:0] cnt_q;

  // A load of N makes expired_o rise in the N-th cycle after the load edge.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= dwell_i - CW'(1);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CW'(1);
    end
  end

  assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/sar_eoc_watch.sv
module sar_eoc_watch #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,
  input  logic eocn_i,
  output logic eoc_fall_o
);

  localparam int unsigned S = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;

  logic [S-1:0] sync_q;
  logic         eoc_lvl;
  logic         hi_seen_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '1;
    end else begin
      sync_q <= {sync_q[S-2:0], eocn_i};
    end
  end

  assign eoc_lvl = sync_q[S-1];

  // The flag must be seen high after arming before a low level counts.
  always_ff @(posedge clk) begin
    if (!rst_n || !arm_i) begin
      hi_seen_q <= 1'b0;
    end else if (eoc_lvl) begin
      hi_seen_q <= 1'b1;
    end
  end

  assign eoc_fall_o = arm_i && hi_seen_q && !eoc_lvl;

endmodule

// File: rtl/sar_chan_counter.sv
module sar_chan_counter #(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned CW     = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          adv_i,
  output logic [CW-1:0] idx_o,
  output logic          last_o
);

  logic [CW-1:0] idx_q;

  assign last_o = (idx_q == CW'(NUM_CH - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || clr_i) begin
      idx_q <= '0;
    end else if (adv_i) begin
      idx_q <= last_o ? '0 : idx_q + CW'(1);
    end
  end

  assign idx_o = idx_q;

endmodule

// File: rtl/sar_bus_ctrl.sv
module sar_bus_ctrl
  import sar_bus_pkg::*;
#(
  parameter int unsigned NUM_CH        = 8,
  parameter int unsigned SAMPLE_W      = 16,
  parameter int unsigned CLK_PERIOD_NS = 5,
  parameter int unsigned QUIET_NS      = 500,
  parameter int unsigned CNV_LOW_NS    = 20,
  parameter int unsigned WR_LOW_NS     = 20,
  parameter int unsigned WR_SETUP_NS   = 10,
  parameter int unsigned RD_LOW_NS     = 30,
  parameter int unsigned RD_HIGH_NS    = 10,
  parameter int unsigned RD_ACCESS_NS  = 35,
  localparam int unsigned CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int unsigned CFG_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                trig_i,
  input  logic                cfg_wr_i,
  input  logic [CFG_W-1:0]    cfg_i,
  output logic                csn_o,
  output logic                rdn_o,
  output logic                wrn_o,
  output logic                cnvst_o,
  input  logic [SAMPLE_W-1:0] db_i,
  output logic [SAMPLE_W-1:0] db_o,
  output logic                db_oe_o,
  input  logic                eocn_i,
  output logic                smp_valid_o,
  output logic [SAMPLE_W-1:0] smp_data_o,
  output logic [CH_W-1:0]     smp_ch_o,
  output logic                smp_last_o,
  output logic                overrun_o
);

  // Dwell of each timed state, in whole clock cycles.
  localparam int unsigned WR_CYC    = max_u(ns_to_cycles(WR_LOW_NS, CLK_PERIOD_NS),
                                            ns_to_cycles(WR_SETUP_NS, CLK_PERIOD_NS));
  localparam int unsigned QUIET_CYC = ns_to_cycles(QUIET_NS, CLK_PERIOD_NS);
  localparam int unsigned CNVL_CYC  = ns_to_cycles(CNV_LOW_NS, CLK_PERIOD_NS);
  localparam int unsigned RDL_CYC   = max_u(ns_to_cycles(RD_LOW_NS, CLK_PERIOD_NS),
                                            ns_to_cycles(RD_ACCESS_NS, CLK_PERIOD_NS) + 1);
  localparam int unsigned RDH_CYC   = ns_to_cycles(RD_HIGH_NS, CLK_PERIOD_NS);
  localparam int unsigned MAX_DWELL = max_u(max_u(WR_CYC, QUIET_CYC),
                                            max_u(CNVL_CYC, max_u(RDL_CYC, RDH_CYC)));
  localparam int unsigned TMR_W     = $clog2(MAX_DWELL + 1);

  seq_state_t        st_q, st_nxt;
  bus_drv_t          drv_q, drv_nxt;
  logic              tmr_load, tmr_done;
  logic [TMR_W-1:0]  tmr_val;
  logic              eoc_fall;
  logic [CH_W-1:0]   ch_idx;
  logic              ch_last;
  logic [CFG_W-1:0]  cfg_q;
  logic              mode_q, mode_nxt;
  logic              overrun_q;
  logic              smp_valid_q, smp_last_q;
  logic [SAMPLE_W-1:0] smp_data_q;
  logic [CH_W-1:0]   smp_ch_q;

  // Named events for the checker and for readability.
  logic seq_idle, trig_acc, cfg_acc, rd_cap_ev;

  assign seq_idle  = (st_q == ST_IDLE);
  assign cfg_acc   = seq_idle && cfg_wr_i;
  assign trig_acc  = seq_idle && !cfg_wr_i && trig_i;
  assign rd_cap_ev = (st_q == ST_RD_LOW) && tmr_done;

  always_comb begin
    st_nxt = st_q;
    case (st_q)
      ST_IDLE: begin
        if (cfg_acc)       st_nxt = ST_WR_ACT;
        else if (trig_acc) st_nxt = ST_QUIET;
      end
      ST_WR_ACT:   if (tmr_done) st_nxt = ST_WR_HOLD;
      ST_WR_HOLD:  if (tmr_done) st_nxt = ST_IDLE;
      ST_QUIET:    if (tmr_done) st_nxt = mode_q ? ST_CNV_LOW : ST_CNV_WAIT;
      ST_CNV_LOW:  if (tmr_done) st_nxt = ST_CNV_WAIT;
      ST_CNV_WAIT: if (eoc_fall) st_nxt = ST_RD_SETUP;
      ST_RD_SETUP: if (tmr_done) st_nxt = ST_RD_LOW;
      ST_RD_LOW:   if (tmr_done) st_nxt = ch_last ? ST_RD_END : ST_RD_HIGH;
      ST_RD_HIGH:  if (tmr_done) st_nxt = ST_RD_LOW;
      ST_RD_END:   if (tmr_done) st_nxt = ST_IDLE;
      default:     st_nxt = ST_IDLE;
    endcase
  end

  // Each entry into a state reloads the dwell timer.
  always_comb begin
    tmr_load = (st_nxt != st_q);
    case (st_nxt)
      ST_WR_ACT:  tmr_val = TMR_W'(WR_CYC);
      ST_QUIET:   tmr_val = TMR_W'(QUIET_CYC);
      ST_CNV_LOW: tmr_val = TMR_W'(CNVL_CYC);
      ST_RD_LOW:  tmr_val = TMR_W'(RDL_CYC);
      ST_RD_HIGH: tmr_val = TMR_W'(RDH_CYC);
      default:    tmr_val = TMR_W'(1);
    endcase
  end

  // The new start mode takes effect as the write completes.
  assign mode_nxt = (st_q == ST_WR_HOLD) ? cfg_q[0] : mode_q;
  assign drv_nxt  = drive_for(st_nxt, mode_nxt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      drv_q  <= drive_for(ST_IDLE, 1'b0);
      mode_q <= 1'b0;
      cfg_q  <= '0;
    end else begin
      st_q   <= st_nxt;
      drv_q  <= drv_nxt;
      mode_q <= mode_nxt;
      if (cfg_acc) cfg_q <= cfg_i;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      overrun_q <= 1'b0;
    end else if (trig_i && !trig_acc) begin
      overrun_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      smp_valid_q <= 1'b0;
      smp_last_q  <= 1'b0;
      smp_data_q  <= '0;
      smp_ch_q    <= '0;
    end else begin
      smp_valid_q <= rd_cap_ev;
      if (rd_cap_ev) begin
        smp_data_q <= db_i;
        smp_ch_q   <= ch_idx;
        smp_last_q <= ch_last;
      end
    end
  end

  sar_dwell_timer #(.CW(TMR_W)) u_tmr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (tmr_load),
    .dwell_i   (tmr_val),
    .expired_o (tmr_done)
  );

  sar_eoc_watch #(.SYNC_STAGES(2)) u_eoc (
    .clk        (clk),
    .rst_n      (rst_n),
    .arm_i      (st_q == ST_CNV_WAIT),
    .eocn_i     (eocn_i),
    .eoc_fall_o (eoc_fall)
  );

  sar_chan_counter #(.NUM_CH(NUM_CH), .CW(CH_W)) u_ch (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (trig_acc),
    .adv_i  (rd_cap_ev),
    .idx_o  (ch_idx),
    .last_o (ch_last)
  );

  assign csn_o       = drv_q.csn;
  assign rdn_o       = drv_q.rdn;
  assign wrn_o       = drv_q.wrn;
  assign cnvst_o     = drv_q.cnvst;
  assign db_oe_o     = drv_q.oe;
  assign db_o        = drv_q.oe ? SAMPLE_W'(cfg_q) : '0;
  assign smp_valid_o = smp_valid_q;
  assign smp_data_o  = smp_data_q;
  assign smp_ch_o    = smp_ch_q;
  assign smp_last_o  = smp_last_q;
  assign overrun_o   = overrun_q;

endmodule

// File: rtl/sar_bus_ctrl_chk.sv
module sar_bus_ctrl_chk #(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned CH_W   = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            csn,
  input logic            rdn,
  input logic            wrn,
  input logic            cnvst,
  input logic            oe,
  input logic            valid,
  input logic            last,
  input logic [CH_W-1:0] ch,
  input logic            overrun,
  input logic            seq_idle
);

  p_wr_with_cs_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wrn |-> (!csn && oe));

  p_cnv_rise_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cnvst) |-> (csn && rdn && wrn));

  p_rd_under_cs_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !rdn |-> !csn);

  p_sample_at_rd_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (rdn && !$past(rdn)));

  p_valid_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);

  p_last_index_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && last) |-> (ch == CH_W'(NUM_CH - 1)));

  p_index_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (int'(ch) < NUM_CH));

  p_no_bus_fight_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rdn |-> (!oe && !$past(oe)));

  p_overrun_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);

  p_wr_from_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wrn) |-> $past(seq_idle));

endmodule

bind sar_bus_ctrl sar_bus_ctrl_chk #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .csn      (csn_o),
  .rdn      (rdn_o),
  .wrn      (wrn_o),
  .cnvst    (cnvst_o),
  .oe       (db_oe_o),
  .valid    (smp_valid_o),
  .last     (smp_last_o),
  .ch       (smp_ch_o),
  .overrun  (overrun_o),
  .seq_idle (seq_idle)
);

// File: tb/sar_bus_ctrl_tb.sv
module sar_bus_ctrl_tb_top;

  localparam int T     = 5;
  localparam int NCH   = 6;
  localparam int W     = 16;
  localparam int WRL   = ((20 + T - 1) / T > (10 + T - 1) / T) ? (20 + T - 1) / T : (10 + T - 1) / T;
  localparam int QUIET = (500 + T - 1) / T;
  localparam int CNVL  = (20 + T - 1) / T;
  localparam int RDL   = ((35 + T - 1) / T + 1 > (30 + T - 1) / T) ? (35 + T - 1) / T + 1 : (30 + T - 1) / T;
  localparam int RDH   = (10 + T - 1) / T;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trig_i = 1'b0;
  logic cfg_wr_i = 1'b0;
  logic [3:0] cfg_i = 4'h0;
  logic csn_o, rdn_o, wrn_o, cnvst_o, db_oe_o;
  logic [W-1:0] db_i = 16'h0BAD;
  logic [W-1:0] db_o;
  logic eocn_i = 1'b0;
  logic smp_valid_o, smp_last_o, overrun_o;
  logic [W-1:0] smp_data_o;
  logic [2:0] smp_ch_o;

  int checks = 0;
  int errors = 0;
  int oe_clash = 0;

  always #2.5 clk = ~clk;

  sar_bus_ctrl #(.NUM_CH(NCH), .SAMPLE_W(W), .CLK_PERIOD_NS(T)) dut_i (
    .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .cfg_wr_i(cfg_wr_i), .cfg_i(cfg_i),
    .csn_o(csn_o), .rdn_o(rdn_o), .wrn_o(wrn_o), .cnvst_o(cnvst_o),
    .db_i(db_i), .db_o(db_o), .db_oe_o(db_oe_o), .eocn_i(eocn_i),
    .smp_valid_o(smp_valid_o), .smp_data_o(smp_data_o), .smp_ch_o(smp_ch_o),
    .smp_last_o(smp_last_o), .overrun_o(overrun_o)
  );

  // Behavioural converter: flag high shortly after a start edge, low ~3 us later;
  // data valid only from the seventh cycle of a read strobe.
  logic cnv_prev_m = 1'b0;
  logic rd_prev_m = 1'b1;
  int eoc_t = 0;
  int rd_low_m = 0;
  logic [7:0] ptr_m = 8'd0;
  logic [3:0] conv_m = 4'd0;

  always @(posedge clk) begin
    cnv_prev_m <= cnvst_o;
    rd_prev_m  <= rdn_o;
    if (!cnv_prev_m && cnvst_o) begin
      eoc_t  <= 1;
      conv_m <= conv_m + 4'd1;
      ptr_m  <= 8'd0;
    end else begin
      if (eoc_t > 0) begin
        eoc_t <= eoc_t + 1;
        if (eoc_t == 12) eocn_i <= 1'b1;
        if (eoc_t == 600) begin
          eocn_i <= 1'b0;
          eoc_t  <= 0;
        end
      end
      if (!rd_prev_m && rdn_o) ptr_m <= ptr_m + 8'd1;
    end
    rd_low_m <= rdn_o ? 0 : rd_low_m + 1;
    db_i <= (!rdn_o && rd_low_m + 1 >= 7) ? {4'hA, conv_m, ptr_m} : 16'h0BAD;
  end

  always @(negedge clk) if (rst_n && !rdn_o && db_oe_o) oe_clash++;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    chk("R1", "strobes high in reset", {csn_o, rdn_o, wrn_o}, 3'b111);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "strobes high after reset", {csn_o, rdn_o, wrn_o}, 3'b111);
    chk("R1", "cnvst/oe/valid/overrun low", {cnvst_o, db_oe_o, smp_valid_o, overrun_o}, 4'b0000);
  endtask

  task automatic t_config(input logic [3:0] val);
    int wr_low = 0, cs_low = 0, oe_cnt = 0, bad = 0;
    @(negedge clk);
    cfg_i = val;
    cfg_wr_i = 1'b1;
    @(negedge clk);
    cfg_wr_i = 1'b0;
    for (int c = 1; c <= 12; c++) begin
      if (c > 1) @(negedge clk);
      if (!wrn_o) begin
        wr_low++;
        if (csn_o || !db_oe_o || db_o[3:0] != val) bad++;
      end
      if (!csn_o) cs_low++;
      if (db_oe_o) oe_cnt++;
      if (c == WRL + 1 && !(db_oe_o && wrn_o)) bad++;
    end
    chk("R2", "write low cycles", wr_low, WRL);
    chk("R2", "chip select low cycles", cs_low, WRL);
    chk("R2", "enable cycles", oe_cnt, WRL + 1);
    chk("R2", "bus/strobe mismatches", bad, 0);
    chk("R2", "enable released", db_oe_o, 0);
    chk("R4", "convert-start idle level", cnvst_o, val[0]);
  endtask

  task automatic t_convert(input logic mode, input bit disturb);
    int first_chg = 0, cnv_low_w = 0, eoc_fall = 0, rd1 = 0, cnv_fall = 0;
    int rd_falls = 0, low_run = 0, high_run = 0, bad_low = 0, bad_high = 0;
    int nsmp = 0, bad_smp = 0;
    logic strobes_ok = 1'b1, wr_seen = 1'b0, cnv_at_rd = 1'b0, cs_prev = 1'b1, cs_before = 1'b1;
    logic prev_cnv, prev_rd, prev_eoc;
    logic [W-1:0] exp;
    @(negedge clk);
    trig_i = 1'b1;
    @(negedge clk);
    trig_i = 1'b0;
    prev_cnv = mode;
    prev_rd = 1'b1;
    prev_eoc = eocn_i;
    for (int c = 1; c <= 1200; c++) begin
      if (c > 1) @(negedge clk);
      if (disturb && c == 300) trig_i = 1'b1;
      if (disturb && c == 301) trig_i = 1'b0;
      if (disturb && c == 350) begin cfg_i = 4'hF; cfg_wr_i = 1'b1; end
      if (disturb && c == 351) cfg_wr_i = 1'b0;
      if (first_chg == 0 && cnvst_o != prev_cnv) first_chg = c;
      if (first_chg == 0 && !(csn_o && rdn_o && wrn_o)) strobes_ok = 1'b0;
      if (mode && !cnvst_o) cnv_low_w++;
      if (!mode && prev_cnv && !cnvst_o && cnv_fall == 0) cnv_fall = c;
      if (prev_eoc && !eocn_i && eoc_fall == 0) eoc_fall = c;
      if (!wrn_o) wr_seen = 1'b1;
      if (prev_rd && !rdn_o) begin
        rd_falls++;
        if (rd_falls == 1) begin
          rd1 = c;
          cnv_at_rd = cnvst_o;
          cs_before = cs_prev;
        end else if (high_run != RDH) bad_high++;
        low_run = 0;
      end
      if (!prev_rd && rdn_o) begin
        if (low_run != RDL) bad_low++;
        high_run = 0;
      end
      if (!rdn_o) low_run++;
      else high_run++;
      if (smp_valid_o) begin
        exp = {4'hA, conv_m, 8'(nsmp)};
        if (smp_data_o != exp || int'(smp_ch_o) != nsmp || smp_last_o != (nsmp == NCH - 1)) begin
          bad_smp++;
          $display("FAIL R7 sample %0d: actual data %h ch %0d last %0b expected data %h ch %0d last %0b",
                   nsmp, smp_data_o, smp_ch_o, smp_last_o, exp, nsmp, (nsmp == NCH - 1));
        end
        nsmp++;
      end
      cs_prev = csn_o;
      prev_cnv = cnvst_o;
      prev_rd = rdn_o;
      prev_eoc = eocn_i;
    end
    chk("R3", "cycles before convert-start moves", first_chg - 1, QUIET);
    chk("R3", "strobes high during quiet", strobes_ok, 1);
    if (mode) chk("R4", "mode 1 low pulse width", cnv_low_w, CNVL);
    chk("R5", "end-of-conversion fall seen before read", (eoc_fall > 0 && rd1 > eoc_fall), 1);
    chk("R6", "read strobe count", rd_falls, NCH);
    chk("R6", "read low width errors", bad_low, 0);
    chk("R6", "read high width errors", bad_high, 0);
    chk("R6", "chip select low before first read", cs_before, 0);
    chk("R7", "sample count", nsmp, NCH);
    chk("R7", "sample mismatches", bad_smp, 0);
    if (!mode) begin
      chk("R8", "convert-start low at first read", cnv_at_rd, 0);
      chk("R8", "convert-start held until flag fall", (cnv_fall > eoc_fall), 1);
    end else begin
      chk("R4", "mode 1 convert-start high at read", cnv_at_rd, 1);
    end
    if (disturb) begin
      chk("R10", "overrun flag set", overrun_o, 1);
      chk("R11", "write strobe during busy", wr_seen, 0);
    end else begin
      chk("R10", "overrun flag state", overrun_o, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_config(4'b0110);
    t_convert(1'b0, 1'b0);
    t_convert(1'b0, 1'b1);
    t_reset();
    t_config(4'b1001);
    repeat (700) @(negedge clk);
    t_convert(1'b1, 1'b0);
    t_convert(1'b1, 1'b0);
    chk("R9", "enable while reading", oe_clash, 0);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule